// File: doc/BRIEF.md
# Timebase-Bit Staged Watchdog

This watchdog watches one chosen bit of a free-running 64-bit timebase counter that lives inside the block. The counter advances by one on every clock where the tick-enable input is high. Every 0-to-1 transition of the chosen bit counts as one watchdog event. Software picks the bit with a 6-bit period value. A larger period value picks a faster-toggling bit, so the timeout is shorter.

Events move the watchdog through three stages. The first event arms it by setting a "next" flag. The second event sets an interrupt flag, which drives a level interrupt when interrupt-enable is on. The third event sends a one-cycle reset request carrying the action code from a sticky reset-action field. The block also records that code in a "last reset" status field, which survives a system reset.

Software keeps the watchdog quiet by pinging it: it writes ones to the two flag bits of the status register. One event interval is 2^(64-period) ticks. Counted from a ping, the interrupt therefore arrives after about 1.5 intervals and the reset after about 2.5.

Top module: `tbw_watchdog`

## Requirements
- R1: While `rst_n` or `por_n` is low, and right after release, the control readback is zero, the status flags are zero, and `irq` and `rst_req` are low.
- R2: The period value is `{ctrl[20:17], ctrl[31:30]}`. It selects timebase bit 63 minus period. An event is a cycle in which that bit is 1 and was 0 on the previous cycle.
- R3: An event while the next flag (status bit 31) is clear sets that flag and changes nothing else.
- R4: An event while the next flag is set and the interrupt flag (status bit 30) is clear sets the interrupt flag. `irq` always equals status bit 30 AND interrupt-enable (control bit 26), so it falls in the same cycle the flag is cleared.
- R5: An event while both flags are set and the reset-action field (control bits 29:28) is nonzero gives a `rst_req` pulse exactly one cycle long. From the cycle of that pulse, status bits 29:28 show the action code. When the field is zero, no pulse is produced.
- R6: The reset-action field can be written only while it holds zero. Once it is nonzero, later control writes leave it unchanged until a reset.
- R7: A status write with a 1 in bit 31 or bit 30 clears that flag, and a 0 leaves the flag as it is. When a clear and an event arrive in the same cycle, the clear wins.
- R8: Period 0 selects timebase bit 63. With interrupt-enable at 0, no flag is set and no interrupt appears within any practical run time.
- R9: The last-reset field (status bits 29:28) keeps its value through `rst_n` and is cleared only by `por_n`.
- R10: The timebase advances only in cycles where `tick_en` is high. With `tick_en` low, no event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the last-reset field |
| tick_en | input | 1 | Timebase advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects status |
| wr_data | input | 32 | Write data |
| ctrl_rdata | output | 32 | Control register readback |
| stat_rdata | output | 32 | Status register readback |
| irq | output | 1 | Level interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A wrong stage state shows at the ports in two ways. A flag can be set one event early or late, which shifts the status readback and `irq` by a whole event interval. Or a reset pulse appears where none should, which shows up on the first cycle after the faulty event. The bench keeps a cycle-accurate model of the timebase and the flags, so a mistake in bit selection or edge detection appears as a status mismatch within two periods of the selected bit. A broken sticky field or a W1C error shows on the first readback after the write. A last-reset field that is cleared by the wrong reset shows right after that reset is released.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned PER_W      = 6;
   // control fields
   localparam int unsigned C_PER_LO   = 30;  // period[1:0]
   localparam int unsigned C_ACT      = 28;  // reset action [29:28]
   localparam int unsigned C_IE       = 26;  // interrupt enable
   localparam int unsigned C_PER_HI   = 17;  // period[5:2]
   // status fields
   localparam int unsigned S_NEXT     = 31;
   localparam int unsigned S_INT      = 30;
   localparam int unsigned S_LAST     = 28;  // last reset [29:28]

   function automatic logic [PER_W-1:0] period_of(input logic [REG_W-1:0] w);
      return {w[C_PER_HI +: 4], w[C_PER_LO +: 2]};
   endfunction
endpackage

// File: rtl/tbw_timebase.sv
module tbw_timebase #(
   parameter int unsigned TB_W  = 64,
   parameter int unsigned PER_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [PER_W-1:0] period,
   output logic             evt
);
   localparam logic [PER_W-1:0] TOP_IDX = PER_W'(TB_W - 1);

   initial begin
      assert (TB_W == (1 << PER_W))
         else $error("timebase width must equal 2**PER_W");
   end

   logic [TB_W-1:0]  tb_q;
   logic [PER_W-1:0] idx;
   logic             sel, sel_q;

   assign idx = TOP_IDX - period;
   assign sel = tb_q[idx];
   assign evt = sel & ~sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_q  <= '0;
         sel_q <= 1'b0;
      end else begin
         if (tick_en) tb_q <= tb_q + TB_W'(1);
         sel_q <= sel;
      end
   end
endmodule

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
   import tbw_pkg::*;
#(
   parameter int unsigned ACT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [PER_W-1:0] period,
   output logic             int_en,
   output logic [ACT_W-1:0] act,
   output logic [REG_W-1:0] rdata
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[27], wdata[25:21], wdata[16:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period <= '0;
         int_en <= 1'b0;
         act    <= '0;
      end else if (wr) begin
         period <= period_of(wdata);
         int_en <= wdata[C_IE];
         if (act == '0) act <= wdata[C_ACT +: ACT_W];
      end
   end

   always_comb begin
      rdata                 = '0;
      rdata[C_PER_LO +: 2]  = period[1:0];
      rdata[C_PER_HI +: 4]  = period[5:2];
      rdata[C_ACT +: ACT_W] = act;
      rdata[C_IE]           = int_en;
   end
endmodule

// File: rtl/tbw_escalate.sv
module tbw_escalate #(
   parameter int unsigned ACT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  logic             evt,
   input  logic             clr_next,
   input  logic             clr_int,
   input  logic [ACT_W-1:0] act,
   output logic             next_f,
   output logic             int_f,
   output logic             req,
   output logic [ACT_W-1:0] last_act
);
   logic fire;
   assign fire = evt & next_f & int_f & (act != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_f <= 1'b0;
         int_f  <= 1'b0;
         req    <= 1'b0;
      end else begin
         req <= fire;
         if (evt && !next_f)              next_f <= 1'b1;
         else if (evt && next_f && !int_f) int_f <= 1'b1;
         if (clr_next) next_f <= 1'b0;
         if (clr_int)  int_f  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    last_act <= '0;
      else if (fire) last_act <= act;
   end
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog
   import tbw_pkg::*;
#(
   parameter int unsigned TB_W  = 64,
   parameter int unsigned ACT_W = 2
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        rst_n,
   input  logic        tick_en,
   input  logic        wr_en,
   input  logic        wr_addr,
   input  logic [31:0] wr_data,
   output logic [31:0] ctrl_rdata,
   output logic [31:0] stat_rdata,
   output logic        irq,
   output logic        rst_req
);
   initial begin
      assert (ACT_W == 2) else $error("reset action field is two bits wide");
   end

   logic             sys_rst_n;
   logic [PER_W-1:0] period;
   logic             int_en, evt, next_f, int_f;
   logic [ACT_W-1:0] act, last_act;
   logic             stat_wr;

   assign sys_rst_n = rst_n & por_n;
   assign stat_wr   = wr_en & wr_addr;

   tbw_timebase #(.TB_W(TB_W), .PER_W(PER_W)) u_tb (
      .clk(clk), .rst_n(sys_rst_n), .tick_en(tick_en),
      .period(period), .evt(evt));

   tbw_ctrl #(.ACT_W(ACT_W)) u_ctrl (
      .clk(clk), .rst_n(sys_rst_n), .wr(wr_en & ~wr_addr), .wdata(wr_data),
      .period(period), .int_en(int_en), .act(act), .rdata(ctrl_rdata));

   tbw_escalate #(.ACT_W(ACT_W)) u_esc (
      .clk(clk), .rst_n(sys_rst_n), .por_n(por_n), .evt(evt),
      .clr_next(stat_wr & wr_data[S_NEXT]), .clr_int(stat_wr & wr_data[S_INT]),
      .act(act), .next_f(next_f), .int_f(int_f), .req(rst_req),
      .last_act(last_act));

   always_comb begin
      stat_rdata                    = '0;
      stat_rdata[S_NEXT]            = next_f;
      stat_rdata[S_INT]             = int_f;
      stat_rdata[S_LAST +: ACT_W]   = last_act;
   end

   assign irq = int_f & int_en;
endmodule

// File: rtl/tbw_watchdog_chk.sv
module tbw_watchdog_chk (
   input logic        clk,
   input logic        por_n,
   input logic        rst_n,
   input logic [31:0] ctrl_rdata,
   input logic [31:0] stat_rdata,
   input logic        irq,
   input logic        rst_req
);
   // R5
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      rst_req |=> !rst_req);
   // R5
   rst_code_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      rst_req |-> (stat_rdata[29:28] == ctrl_rdata[29:28]) && (ctrl_rdata[29:28] != 2'b00));
   // R4
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      irq == (stat_rdata[30] & ctrl_rdata[26]));
   // R6
   act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      ($past(ctrl_rdata[29:28]) != 2'b00) |-> (ctrl_rdata[29:28] == $past(ctrl_rdata[29:28])));
   // R3
   stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $rose(stat_rdata[30]) |-> $past(stat_rdata[31]));
endmodule

bind tbw_watchdog tbw_watchdog_chk u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .ctrl_rdata(ctrl_rdata),
   .stat_rdata(stat_rdata), .irq(irq), .rst_req(rst_req));

// File: tb/tb_tbw_watchdog.sv
`timescale 1ns/1ps
module tb_tbw_watchdog;
   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
   logic        wr_en = 1'b0, wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] ctrl_rdata, stat_rdata;
   logic        irq, rst_req;

   int total = 0, bad = 0, cyc = 0;
   bit cmp_on = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tbw_watchdog dut (.*);

   // reference model, built from the requirements
   logic [63:0] m_tb;
   logic        m_selq, m_next, m_int, m_ie, m_req;
   logic [5:0]  m_per;
   logic [1:0]  m_act, m_last;

   function automatic logic [31:0] ctrl_word(logic [5:0] p, logic [1:0] a, logic ie);
      return {p[1:0], a, 1'b0, ie, 5'b0, p[5:2], 17'b0};
   endfunction
   function automatic logic [31:0] stat_word(logic n, logic i, logic [1:0] l);
      return {n, i, l, 28'b0};
   endfunction

   always @(posedge clk) begin
      logic evt, fire;
      cyc <= cyc + 1;
      if (!por_n) m_last <= 2'b00;
      if (!por_n || !rst_n) begin
         m_tb <= '0; m_selq <= 1'b0; m_next <= 1'b0; m_int <= 1'b0;
         m_ie <= 1'b0; m_req <= 1'b0; m_per <= '0; m_act <= '0;
      end else begin
         evt  = m_tb[63 - m_per] & ~m_selq;
         fire = evt & m_next & m_int & (m_act != 2'b00);
         m_selq <= m_tb[63 - m_per];
         if (tick_en) m_tb <= m_tb + 64'd1;
         m_req <= fire;
         if (fire) m_last <= m_act;
         if (evt && !m_next)              m_next <= 1'b1;
         else if (evt && m_next && !m_int) m_int <= 1'b1;
         if (wr_en && wr_addr && wr_data[31]) m_next <= 1'b0;
         if (wr_en && wr_addr && wr_data[30]) m_int  <= 1'b0;
         if (wr_en && !wr_addr) begin
            m_per <= {wr_data[20:17], wr_data[31:30]};
            m_ie  <= wr_data[26];
            if (m_act == 2'b00) m_act <= wr_data[29:28];
         end
      end
   end

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) if (cmp_on) begin
      chk(ctrl_rdata == ctrl_word(m_per, m_act, m_ie), "R2/R6 control readback",
          ctrl_rdata, ctrl_word(m_per, m_act, m_ie));
      chk(stat_rdata == stat_word(m_next, m_int, m_last), "R3/R4/R7 status readback",
          stat_rdata, stat_word(m_next, m_int, m_last));
      chk(irq == (m_int & m_ie), "R4 irq", 32'(irq), 32'(m_int & m_ie));
      chk(rst_req == m_req, "R5 rst_req", 32'(rst_req), 32'(m_req));
   end

   task automatic wr(bit addr, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      idle(150000);
      chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
      finish_run();
   end

   initial begin
      bit seen;
      void'($urandom(32'd2718));
      idle(3);
      // R1 reset state
      chk(ctrl_rdata == 32'd0, "R1 ctrl after reset", ctrl_rdata, 0);
      chk(stat_rdata == 32'd0, "R1 status after reset", stat_rdata, 0);
      chk({irq, rst_req} == 2'b00, "R1 outputs after reset", 32'({irq, rst_req}), 0);
      @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
      cmp_on = 1'b1;
      chk(stat_rdata == 32'd0, "R1 status after release", stat_rdata, 0);

      // R2..R5: fastest period, interrupt on, action 2
      wr(1'b0, ctrl_word(6'd63, 2'd2, 1'b1));
      tick_en = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < 40 && !seen; i++) begin
         @(negedge clk);
         seen = rst_req;
      end
      chk(seen, "R5 reset pulse after three events", 32'(seen), 1);
      chk(stat_rdata[29:28] == 2'd2, "R5 last-reset code", 32'(stat_rdata[29:28]), 2);
      @(negedge clk);
      chk(!rst_req, "R5 pulse one cycle", 32'(rst_req), 0);
      // R6 sticky action
      wr(1'b0, ctrl_word(6'd63, 2'd1, 1'b1));
      chk(ctrl_rdata[29:28] == 2'd2, "R6 action sticky", 32'(ctrl_rdata[29:28]), 2);

      // R7 ping semantics with timebase stopped (R10)
      tick_en = 1'b0;
      idle(4);
      wr(1'b1, 32'h0);
      chk(stat_rdata[31:30] == 2'b11, "R7 zero write keeps flags", 32'(stat_rdata[31:30]), 3);
      chk(irq, "R4 irq high with flag and enable", 32'(irq), 1);
      wr(1'b1, 32'hC000_0000);
      chk(stat_rdata[31:30] == 2'b00, "R7 ping clears flags", 32'(stat_rdata[31:30]), 0);
      chk(!irq, "R4 irq falls with flag", 32'(irq), 0);
      idle(40);
      chk(stat_rdata[31:30] == 2'b00, "R10 no event without tick", 32'(stat_rdata[31:30]), 0);

      // R8 period 0 and interrupts off
      wr(1'b0, ctrl_word(6'd0, 2'd0, 1'b0));
      tick_en = 1'b1;
      idle(300);
      chk(stat_rdata[31:30] == 2'b00, "R8 period 0 quiet", 32'(stat_rdata[31:30]), 0);
      chk(!irq, "R8 no interrupt", 32'(irq), 0);

      // R9 last-reset survives rst_n, cleared by por_n
      cmp_on = 1'b0;
      rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
      chk(stat_rdata[29:28] == 2'd2, "R9 kept through rst_n", 32'(stat_rdata[29:28]), 2);
      chk(ctrl_rdata == 32'd0, "R6 action cleared by rst_n", ctrl_rdata, 0);
      por_n = 1'b0; idle(2); por_n = 1'b1; idle(1);
      chk(stat_rdata[29:28] == 2'd0, "R9 cleared by por_n", 32'(stat_rdata[29:28]), 0);
      cmp_on = 1'b1;

      // R5 action zero: flags escalate, no pulse
      wr(1'b0, ctrl_word(6'd63, 2'd0, 1'b1));
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         seen |= rst_req;
      end
      chk(!seen, "R5 no pulse with action zero", 32'(seen), 0);

      // random phase, R2 bit selection across periods
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         tick_en = ($urandom % 8) != 0;
         if (r[3:0] == 4'd0)
            wr(1'b0, ctrl_word(6'(58 + ($urandom % 6)), 2'($urandom), 1'($urandom)));
         else if (r[3:0] == 4'd1)
            wr(1'b1, {2'($urandom), 30'($urandom)});
         else if (r[11:4] == 8'd0) begin
            cmp_on = 1'b0;
            rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
            cmp_on = 1'b1;
         end else
            @(negedge clk);
      end
      cmp_on = 1'b0;
      finish_run();
   end
endmodule